// File: doc/BRIEF.md
# Microsequenced Two-Operand Register Core

This block is a small load-store processor core. It executes two-operand register instructions of the form `OP Rd, Rs` as a visible chain of microoperations. A single-port eight-entry register file sits behind a local control unit, which holds an address and a data latch. The ALU has two input latches (RI1, RI2), a result latch (RO) and a four-bit flag register. Only LOAD and STORE reach the data memory. Arithmetic and logic instructions take their operands from registers only, and they write the result back to the first operand, so `Rd = Rd op Rs`.

Programs sit in an internal instruction memory. Data sits in an internal data memory. The bench fills both through a preload port while the core is idle. The user places a start address and a run mode on the inputs and pulses `start`. In automatic mode the core then performs one microoperation per clock. In single-step mode it performs one microoperation per `step` pulse. After each microoperation the debug outputs show the pending microoperation, PC, IR, RI1, RI2, RO and the flags. A HALT returns the sequencer to IDLE.

The sequencer states are encoded on `dbg_uop`. The value names the microoperation that the next advance will perform:
- IDLE=0
- FETCH=1
- ADR1=2 (first operand address to the LCU)
- RD1=3 (register read)
- LAT1=4 (RI1 latch)
- ADR2=5 (second operand address to the LCU)
- RD2=6 (register read)
- LAT2=7 (RI2 latch)
- EXEC=8 (ALU start)
- RES=9 (RO to the LCU, Rd address to the LCU)
- WRB=10 (register write)
- MRD=11 (data memory read into the LCU, Rd address)
- MWR=12 (RI1 written to data memory)

The transitions are:
- IDLE goes to FETCH on start.
- FETCH goes to IDLE on a halting opcode, to ADR2 on LOAD, and to ADR1 otherwise.
- The chain runs ADR1, RD1, LAT1, ADR2, RD2.
- RD2 goes to MRD on LOAD, to MWR on STORE, and to LAT2 otherwise.
- The chain runs LAT2, EXEC, RES, WRB.
- MRD goes to WRB.
- WRB and MWR go to FETCH.

Top module: `cpu_core`

## Requirements
- R1: After reset the core is in IDLE (`dbg_uop`=0, `busy`=0). PC, IR, RI1, RI2, RO, the flags and all eight registers are zero.
- R2: A `start` pulse in IDLE loads PC from `start_addr`, latches `step_mode` as the run mode and enters FETCH. `start` outside IDLE has no effect on the state or the PC, and `step` in IDLE has no effect.
- R3: FETCH loads IR from the instruction memory at PC and increments PC by one, wrapping at the memory size. This holds for halting opcodes too.
- R4: The instruction word is 16 bits:
  - opcode in bits [15:12]
  - first operand Rd in [11:9]
  - second operand Rs in [8:6]
  - bits [5:0] ignored
  The opcodes are 0 HALT, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR, 6 MOV, 7 LOAD and 8 STORE.
- R5: An ALU instruction (opcodes 1 to 6) runs the microoperations 1,2,3,4,5,6,7,8,9,10 in that order, ten in all.
- R6: LOAD runs 1,5,6,11,10 and sets Rd to the data memory word addressed by the low bits of Rs. STORE runs 1,2,3,4,5,6,12 and writes Rd to the data memory word addressed by the low bits of Rs.
- R7: For an ALU instruction, RI1 takes Rd and RI2 takes Rs. RO is Rd+Rs, Rd-Rs, Rd&Rs, Rd|Rs, Rd^Rs or Rs (MOV), and RO is written back to Rd.
- R8: `dbg_flags` = {V,C,N,Z} are set in EXEC:
  - Z means RO is zero.
  - N is the RO sign bit.
  - C is the carry out for ADD and the borrow (Rd<Rs unsigned) for SUB.
  - V is signed overflow for ADD and SUB.
  - C and V are 0 for logic ops and MOV.
- R9: RI1 changes only in LAT1, RI2 only in LAT2, and RO and the flags only in EXEC. LOAD and STORE leave RO and the flags unchanged, and STORE updates RI1.
- R10: In single-step mode the state advances exactly one microoperation per clock on which `step` is high and holds otherwise.
- R11: In automatic mode every clock performs one microoperation. A program therefore takes exactly the sum of its microoperation counts from the start pulse back to IDLE.
- R12: Opcode 0 and the undefined opcodes 9 to 15 end execution in FETCH and return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_we | input | 1 | Preload write enable |
| pre_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pre_addr | input | IAW | Preload address (data memory uses low MAW bits) |
| pre_wdata | input | 16 | Preload word (data memory uses low DW bits) |
| start_addr | input | IAW | Program start address |
| step_mode | input | 1 | 1 single-step, 0 automatic; sampled at start |
| start | input | 1 | Start pulse |
| step | input | 1 | Step pulse in single-step mode |
| busy | output | 1 | Sequencer not in IDLE |
| dbg_uop | output | 4 | Pending microoperation code |
| dbg_pc | output | IAW | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_ri1 | output | DW | ALU input latch 1 |
| dbg_ri2 | output | DW | ALU input latch 2 |
| dbg_ro | output | DW | ALU result latch |
| dbg_flags | output | 4 | Flags {V,C,N,Z} |

## Verification
Register contents never appear at the ports, so every write-back has to be seen through a later instruction that reads that register into RI1 or RI2. The directed program chains LOADs through pointer registers to build 0x7F, 0x01 and 0xFF, then hits signed overflow, carry to zero and borrow. It also stores a value and reads it back. The hardest event to reach is a `start` pulse in the middle of a stepped instruction. The bench holds the core between step pulses, then drives `start` with a different address and a changed mode. It checks that the state, the PC and the latched step mode are untouched. Random programs of LOADs, STOREs and ALU ops over random memory contents alternate between stepped and automatic runs.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int INSTR_W = 16;
    localparam int NREG    = 8;
    localparam int RA_W    = $clog2(NREG);

    localparam logic [3:0] OP_HALT  = 4'd0;
    localparam logic [3:0] OP_ADD   = 4'd1;
    localparam logic [3:0] OP_SUB   = 4'd2;
    localparam logic [3:0] OP_AND   = 4'd3;
    localparam logic [3:0] OP_OR    = 4'd4;
    localparam logic [3:0] OP_XOR   = 4'd5;
    localparam logic [3:0] OP_MOV   = 4'd6;
    localparam logic [3:0] OP_LOAD  = 4'd7;
    localparam logic [3:0] OP_STORE = 4'd8;

    typedef enum logic [3:0] {
        U_IDLE  = 4'd0,
        U_FETCH = 4'd1,
        U_ADR1  = 4'd2,
        U_RD1   = 4'd3,
        U_LAT1  = 4'd4,
        U_ADR2  = 4'd5,
        U_RD2   = 4'd6,
        U_LAT2  = 4'd7,
        U_EXEC  = 4'd8,
        U_RES   = 4'd9,
        U_WRB   = 4'd10,
        U_MRD   = 4'd11,
        U_MWR   = 4'd12
    } uop_e;

    typedef struct packed {
        logic fetch;
        logic adr_rd;
        logic adr_rs;
        logic rf_rd;
        logic rf_wr;
        logic lat1;
        logic lat2;
        logic exec;
        logic res;
        logic mrd;
        logic mwr;
    } ctl_t;

    function automatic logic op_halts(input logic [3:0] op);
        return (op == OP_HALT) || (op > OP_STORE);
    endfunction

endpackage

// File: rtl/cpu_useq.sv
module cpu_useq
    import cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       step_mode,
    input  logic       step,
    input  logic [3:0] fetch_op,
    input  logic [3:0] ir_op,
    output uop_e       uop,
    output logic       fire,
    output logic       step_lat
);

    uop_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uop      <= U_IDLE;
            step_lat <= 1'b0;
        end else begin
            if (uop == U_IDLE && start) step_lat <= step_mode;
            if (fire) uop <= nxt;
        end
    end

    always_comb begin
        fire = (uop == U_IDLE) ? start : (step_lat ? step : 1'b1);
        nxt  = uop;
        unique case (uop)
            U_IDLE:  nxt = U_FETCH;
            U_FETCH: begin
                if (op_halts(fetch_op))      nxt = U_IDLE;
                else if (fetch_op == OP_LOAD) nxt = U_ADR2;
                else                          nxt = U_ADR1;
            end
            U_ADR1:  nxt = U_RD1;
            U_RD1:   nxt = U_LAT1;
            U_LAT1:  nxt = U_ADR2;
            U_ADR2:  nxt = U_RD2;
            U_RD2: begin
                if (ir_op == OP_LOAD)       nxt = U_MRD;
                else if (ir_op == OP_STORE) nxt = U_MWR;
                else                        nxt = U_LAT2;
            end
            U_LAT2:  nxt = U_EXEC;
            U_EXEC:  nxt = U_RES;
            U_RES:   nxt = U_WRB;
            U_WRB:   nxt = U_FETCH;
            U_MRD:   nxt = U_WRB;
            U_MWR:   nxt = U_FETCH;
            default: nxt = U_IDLE;
        endcase
    end

endmodule

// File: rtl/cpu_lcu.sv
module cpu_lcu
    import cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_ld,
    input  logic [RA_W-1:0] addr_in,
    input  logic            data_ld,
    input  logic [DW-1:0]   data_in,
    input  logic            rd,
    input  logic            wr,
    output logic [DW-1:0]   lcu_data
);

    logic [DW-1:0]   regs [NREG];
    logic [RA_W-1:0] lcu_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            lcu_addr <= '0;
            lcu_data <= '0;
        end else begin
            if (addr_ld) lcu_addr <= addr_in;
            if (data_ld)  lcu_data <= data_in;
            else if (rd)  lcu_data <= regs[lcu_addr];
            if (wr) regs[lcu_addr] <= lcu_data;
        end
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat1,
    input  logic          lat2,
    input  logic          exec,
    input  logic [3:0]    op,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] ri1,
    output logic [DW-1:0] ri2,
    output logic [DW-1:0] ro,
    output logic [3:0]    flags
);

    localparam int MSB = DW - 1;

    logic [DW:0]   wide;
    logic [DW-1:0] res;
    logic          cy, ov;

    always_comb begin
        wide = '0;
        cy   = 1'b0;
        ov   = 1'b0;
        unique case (op)
            OP_ADD: begin
                wide = {1'b0, ri1} + {1'b0, ri2};
                res  = wide[DW-1:0];
                cy   = wide[DW];
                ov   = (ri1[MSB] == ri2[MSB]) && (res[MSB] != ri1[MSB]);
            end
            OP_SUB: begin
                wide = {1'b0, ri1} - {1'b0, ri2};
                res  = wide[DW-1:0];
                cy   = wide[DW];
                ov   = (ri1[MSB] != ri2[MSB]) && (res[MSB] != ri1[MSB]);
            end
            OP_AND:  res = ri1 & ri2;
            OP_OR:   res = ri1 | ri2;
            OP_XOR:  res = ri1 ^ ri2;
            default: res = ri2;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ri1   <= '0;
            ri2   <= '0;
            ro    <= '0;
            flags <= '0;
        end else begin
            if (lat1) ri1 <= din;
            if (lat2) ri2 <= din;
            if (exec) begin
                ro    <= res;
                flags <= {ov, cy, res[MSB], (res == '0)};
            end
        end
    end

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int IAW = 5,
    parameter int MAW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pre_we,
    input  logic               pre_sel,
    input  logic [IAW-1:0]     pre_addr,
    input  logic [INSTR_W-1:0] pre_wdata,
    input  logic [IAW-1:0]     start_addr,
    input  logic               step_mode,
    input  logic               start,
    input  logic               step,
    output logic               busy,
    output logic [3:0]         dbg_uop,
    output logic [IAW-1:0]     dbg_pc,
    output logic [INSTR_W-1:0] dbg_ir,
    output logic [DW-1:0]      dbg_ri1,
    output logic [DW-1:0]      dbg_ri2,
    output logic [DW-1:0]      dbg_ro,
    output logic [3:0]         dbg_flags
);

    localparam int IDEPTH = 1 << IAW;
    localparam int MDEPTH = 1 << MAW;

    logic [INSTR_W-1:0] imem [IDEPTH];
    logic [DW-1:0]      dmem [MDEPTH];

    logic [IAW-1:0]     pc;
    logic [INSTR_W-1:0] ir;
    logic [INSTR_W-1:0] fetch_word;
    uop_e               uop;
    logic               fire;
    logic               step_lat;
    ctl_t               ctl;
    logic [DW-1:0]      lcu_data;
    logic [DW-1:0]      ri1, ri2, ro;
    logic [3:0]         flags;
    logic [RA_W-1:0]    f_rd, f_rs;

    assign fetch_word = imem[pc];
    assign f_rd       = ir[11:9];
    assign f_rs       = ir[8:6];

    cpu_useq u_useq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .step_mode(step_mode),
        .step     (step),
        .fetch_op (fetch_word[15:12]),
        .ir_op    (ir[15:12]),
        .uop      (uop),
        .fire     (fire),
        .step_lat (step_lat)
    );

    // Output decode: one strobe per microoperation, only when it is performed
    always_comb begin
        ctl = '0;
        if (fire) begin
            unique case (uop)
                U_FETCH: ctl.fetch  = 1'b1;
                U_ADR1:  ctl.adr_rd = 1'b1;
                U_RD1:   ctl.rf_rd  = 1'b1;
                U_LAT1:  ctl.lat1   = 1'b1;
                U_ADR2:  ctl.adr_rs = 1'b1;
                U_RD2:   ctl.rf_rd  = 1'b1;
                U_LAT2:  ctl.lat2   = 1'b1;
                U_EXEC:  ctl.exec   = 1'b1;
                U_RES:   ctl.res    = 1'b1;
                U_WRB:   ctl.rf_wr  = 1'b1;
                U_MRD:   ctl.mrd    = 1'b1;
                U_MWR:   ctl.mwr    = 1'b1;
                default: ctl = '0;
            endcase
        end
    end

    cpu_lcu #(.DW(DW)) u_lcu (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_ld (ctl.adr_rd | ctl.adr_rs | ctl.res | ctl.mrd),
        .addr_in (ctl.adr_rs ? f_rs : f_rd),
        .data_ld (ctl.res | ctl.mrd),
        .data_in (ctl.mrd ? dmem[lcu_data[MAW-1:0]] : ro),
        .rd      (ctl.rf_rd),
        .wr      (ctl.rf_wr),
        .lcu_data(lcu_data)
    );

    cpu_alu #(.DW(DW)) u_alu (
        .clk  (clk),
        .rst_n(rst_n),
        .lat1 (ctl.lat1),
        .lat2 (ctl.lat2),
        .exec (ctl.exec),
        .op   (ir[15:12]),
        .din  (lcu_data),
        .ri1  (ri1),
        .ri2  (ri2),
        .ro   (ro),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (pre_we && !pre_sel) imem[pre_addr] <= pre_wdata;
        if (ctl.mwr) dmem[lcu_data[MAW-1:0]] <= ri1;
        else if (pre_we && pre_sel) dmem[pre_addr[MAW-1:0]] <= pre_wdata[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else if (uop == U_IDLE && start) begin
            pc <= start_addr;
        end else if (ctl.fetch) begin
            ir <= fetch_word;
            pc <= pc + 1'b1;
        end
    end

    assign busy      = (uop != U_IDLE);
    assign dbg_uop   = uop;
    assign dbg_pc    = pc;
    assign dbg_ir    = ir;
    assign dbg_ri1   = ri1;
    assign dbg_ri2   = ri2;
    assign dbg_ro    = ro;
    assign dbg_flags = flags;

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
    import cpu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int IAW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           step,
    input logic           step_lat,
    input logic           fire,
    input uop_e           uop,
    input logic [IAW-1:0] pc,
    input logic [DW-1:0]  ri1,
    input logic [DW-1:0]  ro,
    input logic [3:0]     flags
);

    p_idle_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uop == U_IDLE && !start) |=> (uop == U_IDLE));

    p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && uop == U_FETCH) |=> (pc == IAW'($past(pc) + 1'b1)));

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && uop == U_EXEC) |=> (flags[0] == (ro == '0)));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && uop == U_EXEC) |=> $stable(flags));

    p_ri1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && uop == U_LAT1) |=> $stable(ri1));

    p_step_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (uop != U_IDLE && step_lat && !step) |=> $stable(uop));

    p_auto_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (uop != U_IDLE && !step_lat) |=> (uop != $past(uop)));

    p_legal_uop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uop <= U_MWR));

endmodule

bind cpu_core cpu_core_chk #(.DW(DW), .IAW(IAW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .step    (step),
    .step_lat(step_lat),
    .fire    (fire),
    .uop     (uop),
    .pc      (pc),
    .ri1     (ri1),
    .ro      (ro),
    .flags   (flags)
);

// File: tb/test_cpu_core.sv
module test_cpu_core;

    localparam int DW  = 8;
    localparam int IAW = 5;
    localparam int MAW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           pre_we = 1'b0, pre_sel = 1'b0;
    logic [IAW-1:0] pre_addr = '0;
    logic [15:0]    pre_wdata = '0;
    logic [IAW-1:0] start_addr = '0;
    logic           step_mode = 1'b0, start = 1'b0, step = 1'b0;
    logic           busy;
    logic [3:0]     dbg_uop, dbg_flags;
    logic [IAW-1:0] dbg_pc;
    logic [15:0]    dbg_ir;
    logic [DW-1:0]  dbg_ri1, dbg_ri2, dbg_ro;

    cpu_core #(.DW(DW), .IAW(IAW), .MAW(MAW)) i_cpu_core (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_sel(pre_sel),
        .pre_addr(pre_addr), .pre_wdata(pre_wdata), .start_addr(start_addr),
        .step_mode(step_mode), .start(start), .step(step), .busy(busy),
        .dbg_uop(dbg_uop), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_ri1(dbg_ri1),
        .dbg_ri2(dbg_ri2), .dbg_ro(dbg_ro), .dbg_flags(dbg_flags)
    );

    int total = 0;
    int bad   = 0;

    logic [15:0]    m_im [1 << IAW];
    logic [DW-1:0]  m_dm [1 << MAW];
    logic [DW-1:0]  m_rf [8];
    logic [IAW-1:0] m_pc;
    logic [15:0]    m_ir;
    logic [DW-1:0]  m_ri1, m_ri2, m_ro;
    logic [3:0]     m_fl;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit halts(input logic [3:0] op);
        return (op == 4'd0) || (op > 4'd8);
    endfunction

    function automatic int seq_len(input logic [3:0] op);
        if (halts(op)) return 1;
        if (op == 4'd7) return 5;
        if (op == 4'd8) return 7;
        return 10;
    endfunction

    function automatic logic [3:0] seq_at(input logic [3:0] op, input int i);
        if (halts(op)) return 4'd1;
        if (op == 4'd7) begin
            case (i)
                0: return 4'd1;
                1: return 4'd5;
                2: return 4'd6;
                3: return 4'd11;
                default: return 4'd10;
            endcase
        end
        if (op == 4'd8) return (i < 6) ? 4'(i + 1) : 4'd12;
        return 4'(i + 1);
    endfunction

    function automatic string seq_tag(input logic [3:0] op);
        if (halts(op)) return "R12";
        if (op == 4'd7 || op == 4'd8) return "R6";
        return "R5";
    endfunction

    task automatic alu_ref(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                           output logic [DW-1:0] r, output logic [3:0] f);
        logic [DW:0] w;
        logic c, v;
        c = 1'b0;
        v = 1'b0;
        case (op)
            4'd1: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[DW-1:0];
                c = w[DW];
                v = (a[DW-1] == b[DW-1]) && (r[DW-1] != a[DW-1]);
            end
            4'd2: begin
                w = {1'b0, a} - {1'b0, b};
                r = w[DW-1:0];
                c = w[DW];
                v = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]);
            end
            4'd3: r = a & b;
            4'd4: r = a | b;
            4'd5: r = a ^ b;
            default: r = b;
        endcase
        f = {v, c, r[DW-1], (r == '0)};
    endtask

    // one instruction of the reference model; returns 1 on a halting fetch
    task automatic model_exec(output bit h);
        logic [3:0] op;
        logic [2:0] rd, rs;
        m_ir = m_im[m_pc];
        m_pc = m_pc + 1'b1;
        op = m_ir[15:12];
        rd = m_ir[11:9];
        rs = m_ir[8:6];
        h  = halts(op);
        if (h) return;
        if (op == 4'd7) begin
            m_rf[rd] = m_dm[m_rf[rs][MAW-1:0]];
        end else if (op == 4'd8) begin
            m_ri1 = m_rf[rd];
            m_dm[m_rf[rs][MAW-1:0]] = m_ri1;
        end else begin
            m_ri1 = m_rf[rd];
            m_ri2 = m_rf[rs];
            alu_ref(op, m_ri1, m_ri2, m_ro, m_fl);
            m_rf[rd] = m_ro;
        end
    endtask

    task automatic check_state(input logic [3:0] op);
        chk("R3", dbg_pc, m_pc);
        chk("R4", dbg_ir, m_ir);
        chk((op == 4'd8) ? "R6" : "R7", dbg_ri1, m_ri1);
        chk(halts(op) || op > 6 ? "R9" : "R7", dbg_ri2, m_ri2);
        chk(halts(op) || op > 6 ? "R9" : "R7", dbg_ro, m_ro);
        chk(halts(op) || op > 6 ? "R9" : "R8", dbg_flags, m_fl);
    endtask

    task automatic preload(input bit sel, input logic [IAW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        pre_we = 1'b1;
        pre_sel = sel;
        pre_addr = a;
        pre_wdata = d;
        @(negedge clk);
        pre_we = 1'b0;
        if (sel) m_dm[a[MAW-1:0]] = d[DW-1:0];
        else m_im[a] = d;
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input int rd, input int rs);
        return {op, 3'(rd), 3'(rs), 6'h15};
    endfunction

    task automatic run_step(input logic [IAW-1:0] addr, input bit poke_in);
        logic [3:0] op;
        logic [IAW-1:0] pc_hold;
        bit fin, h, poke;
        int n;
        poke = poke_in;
        @(negedge clk);
        start_addr = addr;
        step_mode = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        step_mode = 1'b0;
        chk("R2", dbg_pc, addr);
        m_pc = addr;
        fin = 1'b0;
        while (!fin) begin
            op = m_im[m_pc][15:12];
            n = seq_len(op);
            for (int i = 0; i < n; i++) begin
                chk(seq_tag(op), dbg_uop, seq_at(op, i));
                @(negedge clk);
                chk("R10", dbg_uop, seq_at(op, i));
                if (poke && i == 2) begin
                    pc_hold = dbg_pc;
                    start_addr = ~addr;
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    chk("R2", dbg_uop, seq_at(op, i));
                    chk("R2", dbg_pc, pc_hold);
                    @(negedge clk);
                    chk("R2", dbg_uop, seq_at(op, i));
                end
                step = 1'b1;
                @(negedge clk);
                step = 1'b0;
            end
            model_exec(h);
            check_state(op);
            poke = 1'b0;
            if (h) begin
                chk("R12", busy, 0);
                fin = 1'b1;
            end
        end
    endtask

    task automatic run_auto(input logic [IAW-1:0] addr);
        int exp_cyc, cyc;
        bit h;
        logic [3:0] last_op;
        m_pc = addr;
        exp_cyc = 0;
        h = 1'b0;
        while (!h) begin
            last_op = m_im[m_pc][15:12];
            exp_cyc += seq_len(last_op);
            model_exec(h);
        end
        @(negedge clk);
        start_addr = addr;
        step_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R11", cyc, exp_cyc);
        check_state(last_op);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        for (int i = 0; i < (1 << MAW); i++) m_dm[i] = '0;
        for (int i = 0; i < (1 << IAW); i++) m_im[i] = '0;
        m_pc = '0; m_ir = '0; m_ri1 = '0; m_ri2 = '0; m_ro = '0; m_fl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", busy, 0);
        chk("R1", dbg_uop, 0);
        chk("R1", dbg_pc, 0);
        chk("R1", dbg_ir, 0);
        chk("R1", {dbg_ri1, dbg_ri2, dbg_ro, dbg_flags}, 0);
        // R2: step in IDLE does nothing
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        @(negedge clk);
        chk("R2", dbg_uop, 0);
        chk("R2", dbg_pc, 0);

        for (int i = 0; i < (1 << MAW); i++) preload(1'b1, IAW'(i), 16'h0);
        preload(1'b1, 5'd0, 16'h0001);
        preload(1'b1, 5'd1, 16'h007F);
        preload(1'b1, 5'd2, 16'h00FF);
        // directed program: overflow, carry to zero, borrow, store/readback, undefined halt
        preload(1'b0, 5'd0,  ins(4'd7, 1, 0));
        preload(1'b0, 5'd1,  ins(4'd7, 2, 1));
        preload(1'b0, 5'd2,  ins(4'd1, 2, 1));
        preload(1'b0, 5'd3,  ins(4'd6, 5, 1));
        preload(1'b0, 5'd4,  ins(4'd1, 5, 1));
        preload(1'b0, 5'd5,  ins(4'd7, 3, 5));
        preload(1'b0, 5'd6,  ins(4'd1, 3, 1));
        preload(1'b0, 5'd7,  ins(4'd2, 0, 1));
        preload(1'b0, 5'd8,  ins(4'd5, 6, 6));
        preload(1'b0, 5'd9,  ins(4'd4, 6, 2));
        preload(1'b0, 5'd10, ins(4'd8, 2, 1));
        preload(1'b0, 5'd11, ins(4'd7, 7, 1));
        preload(1'b0, 5'd12, ins(4'd3, 7, 3));
        preload(1'b0, 5'd13, 16'hB000);
        run_step(5'd0, 1'b1);
        // directed R8 corner: after ADD R2,R1 flags were N,V; the final AND gives Z only
        chk("R8", dbg_flags, 4'b0001);
        run_auto(5'd0);

        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < (1 << MAW); i++) preload(1'b1, IAW'(i), 16'($urandom()));
            for (int k = 0; k < 14; k++) begin
                logic [3:0] op;
                op = 4'(($urandom() % 8) + 1);
                preload(1'b0, IAW'(16 + k), ins(op, int'($urandom() % 8), int'($urandom() % 8)));
            end
            preload(1'b0, 5'd30, (p % 2) ? 16'h0000 : 16'hF000);
            if (p % 2) run_auto(5'd16);
            else run_step(5'd16, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule